// File: doc/BRIEF.md
# Barrel Thread Sequencer with Per-Thread Interrupts

This block drives the front of a processor pipeline that is shared by eight hardware threads. On every clock it issues the next thread in a fixed rotation, so each thread gets one slot in every eight cycles and sees one eighth of the core clock. The pipeline is eight stages deep. A thread's previous instruction has therefore left the last stage before the thread issues again, and the block needs no stall, bypass or prediction logic. Main memory, which all threads share, is reached in the same thread order, so two threads never touch it in the same cycle.

For the issuing thread the sequencer presents a thread tag and a program counter. The last pipeline stage returns a write-back carrying the tag, the next PC and three control flags: return-from-interrupt, interrupt-enable write and the enable value. Each thread has its own interrupt request line, its own enable bit, an in-service flag and a saved return address. An enabled request is accepted only in the owning thread's slot. When it is accepted, the issued PC is replaced by that thread's vector address.

Top module: `barrel_sequencer`

## Requirements
- R1: `issueTid` is 0 in the first cycle after reset and advances by one every clock, wrapping from 7 to 0.
- R2: While reset is held, `issueTid` is 0 and `issueIrqTaken` is 0. In the first rotation after reset every thread issues `START_PC` (default 0x0200).
- R3: A write-back with `wbValid`=1 and `wbRti`=0 loads `wbPc` into the PC of thread `wbTid` only. The next issue of that thread presents `wbPc`, and the PCs of the other threads are unchanged.
- R4: A thread that receives no write-back keeps its PC and presents the same PC at its next slot.
- R5: After reset every interrupt enable is 0. A request on a thread whose enable is 0 is never accepted.
- R6: When thread t issues with its request high, its enable 1 and no interrupt in service, `issueIrqTaken` is 1 and `issuePc` equals `VEC_BASE + t*VEC_STRIDE` (defaults 0x0040 and 0x0008). A request is acted on only in the owning thread's slot.
- R7: On acceptance the thread's return register captures the PC the thread would otherwise have issued. A write-back with `wbRti`=1 loads that saved value into the thread's PC, ignores `wbPc` and ends the in-service state.
- R8: While a thread's interrupt is in service, further requests on that thread are not accepted until its return-from-interrupt write-back.
- R9: A write-back with `wbIeWr`=1 sets the enable of thread `wbTid` to `wbIeVal` and leaves the enables of all other threads unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Interrupt request level, one bit per thread |
| wbValid | input | 1 | Write-back from the last stage is present |
| wbTid | input | 3 | Thread tag carried with the write-back |
| wbPc | input | 16 | Next PC of the tagged thread |
| wbRti | input | 1 | Write-back is a return from interrupt |
| wbIeWr | input | 1 | Write-back updates the tagged thread's interrupt enable |
| wbIeVal | input | 1 | New enable value when `wbIeWr` is 1 |
| issueTid | output | 3 | Thread issuing this cycle |
| issuePc | output | 16 | PC issued for that thread |
| issueIrqTaken | output | 1 | This slot starts the thread's interrupt handler |

## Verification
The assertions take the pipeline alignment for granted. A write-back always carries the tag of the thread that issued seven cycles earlier, which is the thread after the current issuer, so a write-back and an interrupt acceptance never target the same thread in the same cycle. The stimulus respects this. A pipeline model in the bench records each issued PC and returns that thread's write-back exactly seven cycles later. Directed phases and random phases only choose what that write-back contains (skip, increment, jump, return, enable change) and which request lines are raised, so tags are never generated out of order.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic take;       // accept interrupt for the issuing thread
    logic loadPc;     // normal write-back of next PC
    logic restorePc;  // return-from-interrupt write-back
  } seqStrobe_t;
endpackage

// File: rtl/barrel_ctrl.sv
module barrel_ctrl
  import barrel_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int TID_W   = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] irqReq,
  input  logic               wbValid,
  input  logic [TID_W-1:0]   wbTid,
  input  logic               wbRti,
  input  logic               wbIeWr,
  input  logic               wbIeVal,
  output logic [TID_W-1:0]   tid,
  output seqStrobe_t         strobe
);
  logic [THREADS-1:0] irqEn;
  logic [THREADS-1:0] inIsr;

  // Rotating thread slot
  always_ff @(posedge clk) begin
    if (!rst_n)                      tid <= '0;
    else if (tid == TID_W'(THREADS-1)) tid <= '0;
    else                             tid <= tid + 1'b1;
  end

  always_comb begin
    strobe.take      = irqReq[tid] & irqEn[tid] & ~inIsr[tid];
    strobe.loadPc    = wbValid & ~wbRti;
    strobe.restorePc = wbValid & wbRti;
  end

  // Per-thread enable and in-service state
  for (genvar g = 0; g < THREADS; g++) begin : gen_irq
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irqEn[g] <= 1'b0;
        inIsr[g] <= 1'b0;
      end else begin
        if (wbValid && wbIeWr && wbTid == TID_W'(g)) irqEn[g] <= wbIeVal;
        if (strobe.restorePc && wbTid == TID_W'(g)) inIsr[g] <= 1'b0;
        if (strobe.take && tid == TID_W'(g))        inIsr[g] <= 1'b1;
      end
    end
  end

  // R1: slot advances by exactly one each cycle (modulo thread count)
  assert_rotate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> TID_W'(tid - $past(tid)) == TID_W'(1));

  // R8: an accepted interrupt leaves the thread in service
  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> inIsr[$past(tid)]);

  // R3: write-back tag is aligned with the thread after the issuer
  assert_wb_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> wbTid == TID_W'(tid + 1'b1));
endmodule

// File: rtl/barrel_datapath.sv
module barrel_datapath
  import barrel_pkg::*;
#(
  parameter int THREADS    = 8,
  parameter int TID_W      = $clog2(THREADS),
  parameter int PC_W       = 16,
  parameter int START_PC   = 'h0200,
  parameter int VEC_BASE   = 'h0040,
  parameter int VEC_STRIDE = 'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] tid,
  input  logic [TID_W-1:0] wbTid,
  input  logic [PC_W-1:0]  wbPc,
  input  seqStrobe_t       strobe,
  output logic [PC_W-1:0]  issuePc
);
  logic [PC_W-1:0] pcView  [THREADS];
  logic [PC_W-1:0] retView [THREADS];
  logic [PC_W-1:0] vecView [THREADS];

  for (genvar g = 0; g < THREADS; g++) begin : gen_thr
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_BASE + g * VEC_STRIDE);
    logic [PC_W-1:0] pcQ;
    logic [PC_W-1:0] retQ;
    logic            mySlot;
    logic            myWb;

    assign mySlot = (tid == TID_W'(g));
    assign myWb   = (wbTid == TID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pcQ  <= PC_W'(START_PC);
        retQ <= '0;
      end else begin
        if (strobe.take && mySlot) begin
          retQ <= pcQ;
          pcQ  <= VEC;
        end
        if (strobe.loadPc && myWb)         pcQ <= wbPc;
        else if (strobe.restorePc && myWb) pcQ <= retQ;
      end
    end

    assign pcView[g]  = pcQ;
    assign retView[g] = retQ;
    assign vecView[g] = VEC;
  end

  assign issuePc = strobe.take ? vecView[tid] : pcView[tid];

  // R7: return register captures the thread's pending PC on acceptance
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> retView[$past(tid)] == $past(pcView[tid]));

  // R7: return-from-interrupt restores the saved address
  assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restorePc |=> pcView[$past(wbTid)] == $past(retView[wbTid]));

  // R3: normal write-back lands in the tagged thread's PC
  assert_wbload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadPc |=> pcView[$past(wbTid)] == $past(wbPc));
endmodule

// File: rtl/barrel_sequencer.sv
module barrel_sequencer
  import barrel_pkg::*;
#(
  parameter int THREADS    = 8,
  parameter int TID_W      = $clog2(THREADS),
  parameter int PC_W       = 16,
  parameter int START_PC   = 'h0200,
  parameter int VEC_BASE   = 'h0040,
  parameter int VEC_STRIDE = 'h0008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] irqReq,
  input  logic               wbValid,
  input  logic [TID_W-1:0]   wbTid,
  input  logic [PC_W-1:0]    wbPc,
  input  logic               wbRti,
  input  logic               wbIeWr,
  input  logic               wbIeVal,
  output logic [TID_W-1:0]   issueTid,
  output logic [PC_W-1:0]    issuePc,
  output logic               issueIrqTaken
);
  seqStrobe_t strobe;

  barrel_ctrl #(.THREADS(THREADS), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq),
    .wbValid(wbValid), .wbTid(wbTid), .wbRti(wbRti),
    .wbIeWr(wbIeWr), .wbIeVal(wbIeVal),
    .tid(issueTid), .strobe(strobe)
  );

  barrel_datapath #(
    .THREADS(THREADS), .TID_W(TID_W), .PC_W(PC_W), .START_PC(START_PC),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tid(issueTid), .wbTid(wbTid),
    .wbPc(wbPc), .strobe(strobe), .issuePc(issuePc)
  );

  assign issueIrqTaken = strobe.take;

  // R6: an accepted interrupt issues the thread's own vector
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issueIrqTaken |-> issuePc == PC_W'(VEC_BASE + int'(issueTid) * VEC_STRIDE));
endmodule

// File: tb/barrel_sequencer_tb.sv
module barrel_sequencer_tb;
  localparam int N = 8;
  localparam logic [15:0] START = 16'h0200;

  typedef enum int {M_NORM, M_HOLD, M_RTI, M_EN, M_DIS, M_JUMP} wbMode_e;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  irqReq = '0;
  logic        wbValid = 0;
  logic [2:0]  wbTid = '0;
  logic [15:0] wbPc = '0;
  logic        wbRti = 0, wbIeWr = 0, wbIeVal = 0;
  logic [2:0]  issueTid;
  logic [15:0] issuePc;
  logic        issueIrqTaken;

  barrel_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .wbValid(wbValid),
    .wbTid(wbTid), .wbPc(wbPc), .wbRti(wbRti), .wbIeWr(wbIeWr),
    .wbIeVal(wbIeVal), .issueTid(issueTid), .issuePc(issuePc),
    .issueIrqTaken(issueIrqTaken)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nRun = 0, nFail = 0;
  // behavioural reference state
  int          mTid, cyc;
  logic [15:0] mPc [N], mRet [N], lastPc [N], jumpTo [N];
  bit          mEn [N], mIsr [N], restored [N], ackPend [N];
  wbMode_e     mode [N];
  int          took [N];
  bit          autoAck = 0;

  function automatic logic [15:0] vecOf(int t);
    return 16'(16'h0040 + t * 8);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    int t = mTid;
    int w = (t + 1) % N;
    bit expTaken;
    logic [15:0] expPc;
    string tag;
    for (int i = 0; i < N; i++) if (ackPend[i]) begin irqReq[i] = 1'b0; ackPend[i] = 0; end
    wbValid = 0; wbRti = 0; wbIeWr = 0; wbIeVal = 0; wbTid = 3'(w); wbPc = '0;
    if (cyc >= 7 && mode[w] != M_HOLD) begin
      wbValid = 1; wbPc = lastPc[w] + 16'd1;
      case (mode[w])
        M_RTI:  begin wbRti = 1; wbPc = 16'hDEAD; end
        M_EN:   begin wbIeWr = 1; wbIeVal = 1; end
        M_DIS:  begin wbIeWr = 1; wbIeVal = 0; end
        M_JUMP: wbPc = jumpTo[w];
        default: ;
      endcase
      mode[w] = M_NORM;
    end
    #1;
    expTaken = irqReq[t] && mEn[t] && !mIsr[t];
    expPc = expTaken ? vecOf(t) : mPc[t];
    check(issueTid == 3'(t), "R1", "issueTid", issueTid, t);
    tag = expTaken ? "R6" : restored[t] ? "R7" : (mode[t] == M_HOLD) ? "R4" : (cyc < 8) ? "R2" : "R3";
    check(issuePc == expPc, tag, "issuePc", issuePc, expPc);
    tag = expTaken ? "R6" : (irqReq[t] && !mEn[t]) ? "R5" : (irqReq[t] && mIsr[t]) ? "R8" : "R6";
    check(issueIrqTaken == expTaken, tag, "issueIrqTaken", issueIrqTaken, expTaken);
    restored[t] = 0;
    lastPc[t] = expPc;
    if (expTaken) begin
      took[t]++; mRet[t] = mPc[t]; mPc[t] = vecOf(t); mIsr[t] = 1;
      if (autoAck) ackPend[t] = 1;
    end
    if (wbValid) begin
      if (wbIeWr) mEn[w] = wbIeVal;
      if (wbRti) begin mPc[w] = mRet[w]; mIsr[w] = 0; restored[w] = 1; end
      else mPc[w] = wbPc;
    end
    mTid = w; cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int others;
    for (int i = 0; i < N; i++) begin
      mPc[i] = START; mRet[i] = '0; lastPc[i] = START; jumpTo[i] = '0;
      mEn[i] = 0; mIsr[i] = 0; restored[i] = 0; ackPend[i] = 0; mode[i] = M_NORM; took[i] = 0;
    end
    mTid = 0; cyc = 0;
    // R2: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(issueTid == 3'd0, "R2", "issueTid in reset", issueTid, 0);
      check(issueIrqTaken == 1'b0, "R2", "issueIrqTaken in reset", issueIrqTaken, 0);
    end
    @(negedge clk); rst_n = 1;

    run(16);                                   // R1 R2 R3 rotation and increments
    mode[5] = M_HOLD; run(16); mode[5] = M_NORM; run(8);   // R4
    jumpTo[2] = 16'h0400; mode[2] = M_JUMP; run(16);       // R3 jump
    irqReq = 8'hFF; run(24);                   // R5: nothing enabled
    mode[2] = M_EN; run(24);                   // R9: enable thread 2 only
    others = 0;
    for (int i = 0; i < N; i++) if (i != 2) others += took[i];
    check(took[2] == 1, "R9", "takes on enabled thread", took[2], 1);
    check(others == 0, "R9", "takes on other threads", others, 0);
    run(16);                                   // R8: held request stays masked
    check(took[2] == 1, "R8", "no retake while in service", took[2], 1);
    mode[2] = M_RTI; run(16);                  // R7 restore, then retake
    check(took[2] == 2, "R8", "retake after return", took[2], 2);
    irqReq = 8'h00; mode[2] = M_RTI; run(16);  // R7
    autoAck = 1; irqReq[6] = 1; mode[6] = M_EN; run(24);
    check(took[6] == 1, "R6", "thread 6 accepted once", took[6], 1);
    mode[6] = M_RTI; run(16);
    mode[2] = M_DIS; run(8); irqReq[2] = 1; run(24);       // R9 disable
    check(took[2] == 2, "R9", "disabled thread not taken", took[2], 2);
    irqReq[2] = 0;
    for (int i = 0; i < 3000; i++) begin       // random mix
      int r = $urandom_range(0, 39);
      int th = $urandom_range(0, N - 1);
      if (mode[th] == M_HOLD && r > 5) mode[th] = M_NORM;
      else if (mode[th] == M_NORM)
        case (r)
          0: mode[th] = M_HOLD;
          1, 2: mode[th] = M_RTI;
          3, 4: mode[th] = M_EN;
          5: mode[th] = M_DIS;
          6: begin jumpTo[th] = 16'($urandom()); mode[th] = M_JUMP; end
          7, 8: irqReq[th] = 1'b1;
          default: ;
        endcase
      tick();
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule